// File: doc/BRIEF.md
# Stack Call Return Controller

This block carries out the stack and control-transfer commands of a word-addressed processor. It keeps the stack pointer and the program counter itself. Five operations are handled: pushing a word onto the stack, popping a word off it, calling a subroutine, returning from one, and jumping. Data reaches the block from three places: a register-file read port, an in-line operand word supplied with the command, and a single memory port whose reads return data one cycle after the request. The stack grows toward lower addresses. A store is always made at the current stack pointer, after which the pointer is decremented. A load is always preceded by an increment of the pointer.

The surrounding core presents a command when `busy` is low and then waits for the one-cycle `done` pulse. When `pc` is sampled together with a command, it must already point to the word after the command, which is where any in-line operand sits. A return can release a number of stack words, given in the command's register field, before it pops the saved program counter. Stack pointer arithmetic wraps modulo 2^32 and never signals an error. The block has no flag logic of its own, so its pointer arithmetic leaves the core's status flags untouched.

Top module: `scr_stack_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `sp` = SP_INIT, `pc` = PC_INIT, and `busy`, `done`, `mem_req` and `rf_we` are all low.
- R2: PUSH (`cmd_op` = 2'b00) with `cmd_ext[0]` = 0 works as follows. In the first cycle after acceptance, it writes the register named by `cmd_field` to memory at the old `sp`. At that same edge `sp` decrements by one, `pc` does not change, and `done` is high in that following cycle.
- R3: PUSH with `cmd_ext[0]` = 1 stores `cmd_imm` in place of the register value and advances `pc` by one. The cycle timing is the same as in R2.
- R4: POP (`cmd_op` = 2'b01) proceeds in order. One cycle after acceptance, `sp` increments. The next cycle issues a read at the new `sp`. The cycle after that writes the returned word to register `cmd_field`. `done` is high one cycle later, that is, four cycles after acceptance.
- R5: In the flow group (`cmd_op` = 2'b10), `cmd_ext[0]` = 0 selects RET, whatever the values of `cmd_ext[2:1]`. RET sets `sp` to `sp + cmd_field + 1` (the field value itself), reads memory at that address, and loads `pc` from the returned word. Its timing is the same as POP's.
- R6: Flow group with `cmd_ext[1:0]` = 2'b01 selects JMP. `pc` is loaded from register `cmd_field` when `cmd_ext[2]` = 1, and from `cmd_imm` when `cmd_ext[2]` = 0. There is no memory access, `sp` does not change, and `done` comes two cycles after acceptance.
- R7: Flow group with `cmd_ext[1:0]` = 2'b11 selects CALL. It stores a return address at the old `sp`. The return address is `pc` for the register form (`cmd_ext[2]` = 1) and `pc + 1` for the in-line form. CALL then decrements `sp` and loads `pc` with the target chosen as in R6. The timing is the same as PUSH's.
- R8: `sp` wraps without error in both directions: a store at 0 leaves 32'hFFFFFFFF, and a load from 32'hFFFFFFFF reads address 0.
- R9: `cmd_op` = 2'b11 is reserved. It makes no memory or register access, leaves `sp` and `pc` unchanged, and produces `done` two cycles after acceptance.
- R10: `busy` is high from the cycle after acceptance until the `done` cycle. Any `cmd_valid` that arrives while `busy` is high is ignored. `done` lasts one cycle. While the block is idle it makes no memory or register access, and `sp` and `pc` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when `busy` is low |
| cmd_op | input | 2 | Operation class: push, pop, flow group, reserved |
| cmd_ext | input | 3 | Extension bits: in-line/form select, call/jump select, register-target select |
| cmd_field | input | RAW | Register number, or the stack-release count for RET |
| cmd_imm | input | DW | In-line operand word |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | RAW | Register-file read address (follows `cmd_field`) |
| rf_rdata | input | DW | Register-file read data, combinational |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | RAW | Register-file write address |
| rf_wdata | output | DW | Register-file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | DW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read request |
| sp | output | DW | Stack pointer |
| pc | output | DW | Program counter |

## Verification
A corrupted stack pointer shows up at the memory address port in the same cycle as the next store or load. An off-by-one in the ordering, such as decrementing before the store or loading before the increment, therefore appears as a wrong `mem_addr` within one or two cycles of the command being accepted. A wrong sequencer state shows at once as a `mem_req`, `rf_we` or `done` in the wrong cycle. A wrong saved return address or pushed value stays hidden until the matching RET or POP, when it reappears as a wrong `pc` or register write. For that reason each push and call is paired later with a pop or return.

// File: rtl/scr_pkg.sv
// Shared types for the stack call return controller.
// Assumes a two-bit operation class and a three-bit extension field.
package scr_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_FLOW = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ACT_PUSH,
        ACT_POP,
        ACT_RET,
        ACT_JMP,
        ACT_CALL,
        ACT_NONE
    } act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STORE,
        ST_BUMP,
        ST_FETCH,
        ST_LOAD,
        ST_JUMP
    } state_e;

    typedef enum logic [1:0] {
        SPOP_HOLD,
        SPOP_DEC,
        SPOP_BUMP
    } sp_op_e;

endpackage

// File: rtl/scr_decode.sv
// Command decoder: maps operation class and extension bits to one action.
// Purely combinational; assumes the flow-group bit meanings of the brief.
module scr_decode
    import scr_pkg::*;
(
    input  op_e        op,
    input  logic [2:0] ext,
    output act_e       act
);

    // Pick the action from the class, then from the extension bits in the flow group
    always_comb begin
        case (op)
            OP_PUSH: act = ACT_PUSH;
            OP_POP:  act = ACT_POP;
            OP_FLOW: begin
                if (!ext[0])      act = ACT_RET;
                else if (!ext[1]) act = ACT_JMP;
                else              act = ACT_CALL;
            end
            default: act = ACT_NONE;
        endcase
    end

endmodule

// File: rtl/scr_sp_unit.sv
// Stack pointer register with hold, decrement and bump-by-count+1 operations.
// Arithmetic wraps modulo 2^DW; it produces no status of any kind.
module scr_sp_unit
    import scr_pkg::*;
#(
    parameter int          DW      = 32,
    parameter int          RAW     = 5,
    parameter logic [DW-1:0] SP_INIT = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  sp_op_e         op,
    input  logic [RAW-1:0] cnt,
    output logic [DW-1:0]  sp
);

    localparam logic [DW-1:0] ONE = DW'(1);

    // Update the pointer according to the requested operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_INIT;
        end else begin
            case (op)
                SPOP_DEC:  sp <= sp - ONE;
                SPOP_BUMP: sp <= sp + DW'(cnt) + ONE;
                default:   sp <= sp;
            endcase
        end
    end

endmodule

// File: rtl/scr_seq.sv
// Command sequencer: one state per memory or register step, done pulse at the end.
// Assumes 'start' is only raised while the sequencer is in ST_IDLE.
module scr_seq
    import scr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  act_e   act_d,
    output state_e state,
    output logic   done
);

    state_e nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    case (act_d)
                        ACT_PUSH, ACT_CALL: nxt = ST_STORE;
                        ACT_POP,  ACT_RET:  nxt = ST_BUMP;
                        default:            nxt = ST_JUMP;
                    endcase
                end
            end
            ST_BUMP:  nxt = ST_FETCH;
            ST_FETCH: nxt = ST_LOAD;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_STORE) || (state == ST_LOAD) || (state == ST_JUMP);
        end
    end

endmodule

// File: rtl/scr_stack_ctrl.sv
// Stack call return controller top.
// Executes push, pop, call, return and jump on a descending, word-addressed
// stack. Stores go to SP and then SP decrements; loads are preceded by an SP
// increment. Assumes combinational register-file reads, a single memory port
// with one-cycle read latency, and a pc that already points past the command.
module scr_stack_ctrl
    import scr_pkg::*;
#(
    parameter int            DW      = 32,
    parameter int            RAW     = 5,
    parameter logic [DW-1:0] SP_INIT = 32'h0000_00FF,
    parameter logic [DW-1:0] PC_INIT = 32'h0000_0010
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [2:0]     cmd_ext,
    input  logic [RAW-1:0] cmd_field,
    input  logic [DW-1:0]  cmd_imm,
    output logic           busy,
    output logic           done,
    output logic [RAW-1:0] rf_raddr,
    input  logic [DW-1:0]  rf_rdata,
    output logic           rf_we,
    output logic [RAW-1:0] rf_waddr,
    output logic [DW-1:0]  rf_wdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [DW-1:0]  sp,
    output logic [DW-1:0]  pc
);

    localparam logic [DW-1:0] ONE = DW'(1);

    act_e           act_d;
    act_e           act_q;
    state_e         state;
    sp_op_e         sp_op;
    logic           start;
    logic           inline_q;
    logic           regsel_q;
    logic [RAW-1:0] field_q;
    logic [DW-1:0]  imm_q;
    logic [DW-1:0]  reg_q;
    logic [DW-1:0]  target;
    logic [RAW-1:0] bump_cnt;

    scr_decode u_dec (
        .op  (op_e'(cmd_op)),
        .ext (cmd_ext),
        .act (act_d)
    );

    scr_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .act_d (act_d),
        .state (state),
        .done  (done)
    );

    scr_sp_unit #(
        .DW      (DW),
        .RAW     (RAW),
        .SP_INIT (SP_INIT)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (sp_op),
        .cnt   (bump_cnt),
        .sp    (sp)
    );

    assign busy     = (state != ST_IDLE);
    assign start    = cmd_valid && !busy;
    assign rf_raddr = cmd_field;

    // Capture the command and its operands when accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= ACT_NONE;
            inline_q <= 1'b0;
            regsel_q <= 1'b0;
            field_q  <= '0;
            imm_q    <= '0;
            reg_q    <= '0;
        end else if (start) begin
            act_q    <= act_d;
            inline_q <= cmd_ext[0];
            regsel_q <= cmd_ext[2];
            field_q  <= cmd_field;
            imm_q    <= cmd_imm;
            reg_q    <= rf_rdata;
        end
    end

    // Jump and call target: register copy or in-line word
    assign target = regsel_q ? reg_q : imm_q;

    // Memory port, stack pointer control and register write-back per state
    always_comb begin
        mem_req   = (state == ST_STORE) || (state == ST_FETCH);
        mem_we    = (state == ST_STORE);
        mem_addr  = sp;
        mem_wdata = '0;
        if (act_q == ACT_PUSH) begin
            mem_wdata = inline_q ? imm_q : reg_q;
        end else if (act_q == ACT_CALL) begin
            mem_wdata = regsel_q ? pc : pc + ONE;
        end
        case (state)
            ST_STORE: sp_op = SPOP_DEC;
            ST_BUMP:  sp_op = SPOP_BUMP;
            default:  sp_op = SPOP_HOLD;
        endcase
        bump_cnt = (act_q == ACT_RET) ? field_q : '0;
        rf_we    = (state == ST_LOAD) && (act_q == ACT_POP);
        rf_waddr = field_q;
        rf_wdata = mem_rdata;
    end

    // Program counter updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= PC_INIT;
        end else begin
            case (state)
                ST_STORE: begin
                    if (act_q == ACT_CALL)  pc <= target;
                    else if (inline_q)      pc <= pc + ONE;
                end
                ST_JUMP: begin
                    if (act_q == ACT_JMP)   pc <= target;
                end
                ST_LOAD: begin
                    if (act_q == ACT_RET)   pc <= mem_rdata;
                end
                default: pc <= pc;
            endcase
        end
    end

endmodule

// File: rtl/scr_stack_ctrl_chk.sv
// Protocol checker for scr_stack_ctrl; observes ports only.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module scr_stack_ctrl_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          rf_we,
    input logic [DW-1:0] sp,
    input logic [DW-1:0] pc
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we)); // R10

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> ($stable(sp) && $stable(pc))); // R10

    AST_STORE_THEN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (sp == $past(sp) - DW'(1))); // R2

    AST_READ_THEN_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> ##1 done); // R4

    AST_WRITEBACK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> done); // R4

endmodule

bind scr_stack_ctrl scr_stack_ctrl_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .rf_we     (rf_we),
    .sp        (sp),
    .pc        (pc)
);

// File: tb/scr_stack_ctrl_tb.sv
// Bench for scr_stack_ctrl: behavioural model of SP, PC, registers and memory,
// compared against the ports on every clock of every command.
module scr_stack_ctrl_tb;

    localparam int            DW  = 32;
    localparam int            RAW = 5;
    localparam logic [DW-1:0] SPI = 32'h0000_0003;
    localparam logic [DW-1:0] PCI = 32'h0000_0010;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_op = 2'b00;
    logic [2:0]     cmd_ext = 3'b000;
    logic [RAW-1:0] cmd_field = '0;
    logic [DW-1:0]  cmd_imm = '0;
    logic           busy, done, rf_we, mem_req, mem_we;
    logic [RAW-1:0] rf_raddr, rf_waddr;
    logic [DW-1:0]  rf_rdata, rf_wdata, mem_addr, mem_wdata, sp, pc;
    logic [DW-1:0]  mem_rdata = '0;

    logic [DW-1:0]  rf_arr  [32];
    logic [DW-1:0]  mem_arr [256];
    logic [DW-1:0]  exp_rf  [32];
    logic [DW-1:0]  exp_mem [256];
    logic [DW-1:0]  exp_sp, exp_pc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    scr_stack_ctrl #(.DW(DW), .RAW(RAW), .SP_INIT(SPI), .PC_INIT(PCI)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ext(cmd_ext), .cmd_field(cmd_field), .cmd_imm(cmd_imm),
        .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp(sp), .pc(pc)
    );

    assign rf_rdata = rf_arr[rf_raddr];

    always @(posedge clk) begin
        if (rf_we) rf_arr[rf_waddr] <= rf_wdata;
        if (mem_req) begin
            if (mem_we) mem_arr[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem_arr[mem_addr[7:0]];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Issue one command; model it and compare the ports on every following cycle
    task automatic run_cmd(input string req, input logic [1:0] op, input logic [2:0] ext,
                           input logic [RAW-1:0] fld, input logic [DW-1:0] imm,
                           input bit hold_valid);
        bit is_store, is_load, is_pop, is_ret;
        int lat;
        logic [DW-1:0] waddr, wdata, raddr, tgt, n_sp, n_pc;
        is_pop   = (op == 2'b01);
        is_ret   = (op == 2'b10) && !ext[0];
        is_store = (op == 2'b00) || ((op == 2'b10) && ext[0] && ext[1]);
        is_load  = is_pop || is_ret;
        lat      = is_load ? 4 : 2;
        tgt      = ext[2] ? exp_rf[fld] : imm;
        waddr    = exp_sp;
        wdata    = '0;
        raddr    = '0;
        n_sp     = exp_sp;
        n_pc     = exp_pc;
        if (op == 2'b00) begin
            wdata = ext[0] ? imm : exp_rf[fld];
            n_sp  = exp_sp - 1;
            n_pc  = exp_pc + (ext[0] ? 1 : 0);
        end else if (is_store) begin
            wdata = ext[2] ? exp_pc : exp_pc + 1;
            n_sp  = exp_sp - 1;
            n_pc  = tgt;
        end else if (is_pop) begin
            n_sp  = exp_sp + 1;
            raddr = n_sp;
        end else if (is_ret) begin
            n_sp  = exp_sp + DW'(fld) + 1;
            raddr = n_sp;
            n_pc  = exp_mem[n_sp[7:0]];
        end else if (op == 2'b10) begin
            n_pc  = tgt;
        end

        @(negedge clk);
        check(!busy, "R10", "busy before accept", DW'(busy), 0);
        cmd_valid = 1'b1; cmd_op = op; cmd_ext = ext; cmd_field = fld; cmd_imm = imm;
        @(negedge clk);
        if (hold_valid) begin
            cmd_op = 2'b00; cmd_ext = 3'b001; cmd_imm = 32'hBAD0_BAD0;
        end else begin
            cmd_valid = 1'b0;
        end
        for (int k = 0; k < lat; k++) begin
            bit e_req, e_we, e_rf;
            if (k > 0) @(negedge clk);
            if (k == lat - 1) cmd_valid = 1'b0;
            e_req = (is_store && k == 0) || (is_load && k == 1);
            e_we  = is_store && k == 0;
            e_rf  = is_pop && k == 2;
            check(mem_req == e_req, req, "mem_req", DW'(mem_req), DW'(e_req));
            check(rf_we == e_rf, req, "rf_we", DW'(rf_we), DW'(e_rf));
            check(done == (k == lat - 1), "R10", "done timing", DW'(done), DW'(k == lat - 1));
            check(busy == (k < lat - 1), "R10", "busy timing", DW'(busy), DW'(k < lat - 1));
            if (e_req) begin
                check(mem_we == e_we, req, "mem_we", DW'(mem_we), DW'(e_we));
                check(mem_addr == (e_we ? waddr : raddr), req, "mem_addr", mem_addr,
                      e_we ? waddr : raddr);
                if (e_we) check(mem_wdata == wdata, req, "mem_wdata", mem_wdata, wdata);
            end
            if (e_rf) begin
                check(rf_waddr == DW'(fld), req, "rf_waddr", DW'(rf_waddr), DW'(fld));
                check(rf_wdata == exp_mem[raddr[7:0]], req, "rf_wdata", rf_wdata,
                      exp_mem[raddr[7:0]]);
            end
        end
        check(sp == n_sp, req, "sp", sp, n_sp);
        check(pc == n_pc, req, "pc", pc, n_pc);
        if (is_store) exp_mem[waddr[7:0]] = wdata;
        if (is_pop)   exp_rf[fld] = exp_mem[raddr[7:0]];
        exp_sp = n_sp;
        exp_pc = n_pc;
    endtask

    // Idle cycles: nothing moves
    task automatic idle_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!mem_req && !rf_we && !done, "R10", "idle quiet",
                  {29'd0, mem_req, rf_we, done}, 0);
            check(sp == exp_sp && pc == exp_pc, "R10", "idle hold sp", sp, exp_sp);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            rf_arr[i] = 32'hA000_0000 + DW'(i) * 32'h111;
            exp_rf[i] = rf_arr[i];
        end
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = '0;
            exp_mem[i] = '0;
        end
        exp_sp = SPI;
        exp_pc = PCI;
        repeat (3) @(negedge clk);
        check(sp == SPI, "R1", "reset sp", sp, SPI);
        check(pc == PCI, "R1", "reset pc", pc, PCI);
        check(!busy && !done && !mem_req && !rf_we, "R1", "reset controls",
              {28'd0, busy, done, mem_req, rf_we}, 0);
        rst_n = 1'b1;
        idle_check(2);

        run_cmd("R2", 2'b00, 3'b000, 5'd3, 32'h0, 1'b0);
        run_cmd("R3", 2'b00, 3'b001, 5'd9, 32'hDEAD_BEEF, 1'b0);
        run_cmd("R3", 2'b00, 3'b001, 5'd0, 32'h1234_5678, 1'b0);
        run_cmd("R8", 2'b00, 3'b000, 5'd5, 32'h0, 1'b0);
        run_cmd("R8", 2'b01, 3'b000, 5'd7, 32'h0, 1'b0);
        run_cmd("R4", 2'b01, 3'b000, 5'd8, 32'h0, 1'b1);
        run_cmd("R6", 2'b10, 3'b001, 5'd2, 32'h0000_0200, 1'b0);
        run_cmd("R6", 2'b10, 3'b101, 5'd3, 32'hFFFF_0000, 1'b0);
        idle_check(2);
        run_cmd("R7", 2'b10, 3'b011, 5'd1, 32'h0000_0400, 1'b0);
        run_cmd("R7", 2'b10, 3'b111, 5'd4, 32'h0, 1'b1);
        run_cmd("R5", 2'b10, 3'b000, 5'd0, 32'h0, 1'b0);
        run_cmd("R5", 2'b10, 3'b110, 5'd1, 32'h0, 1'b0);
        run_cmd("R9", 2'b11, 3'b111, 5'd6, 32'h5555_AAAA, 1'b0);
        run_cmd("R2", 2'b00, 3'b000, 5'd7, 32'h0, 1'b0);
        run_cmd("R4", 2'b01, 3'b000, 5'd12, 32'h0, 1'b0);
        idle_check(3);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule